// File: doc/BRIEF.md
# Barrel Shifter with Shift-Out Carry

This block shifts a 32-bit operand left logically, right logically or right arithmetically by 0 to 31 places in a single combinational pass, then registers the result together with a set of condition flags. The shift count comes from one of two sources. One is a 5-bit immediate, zero-extended. The other is the low five bits of a general register, which the caller has already sliced off.

The flag bundle gives four values. Zero and sign are derived from the shifted result. Carry is the bit that left the operand last. Overflow is always cleared. The result and the flags appear one cycle after a valid request, and a matching valid strobe marks the cycle in which the flags should be written. Instruction decode and register access belong to the surrounding pipeline.

Top module: `barrel_shift_unit`

## Requirements
- R1: With mode code 2'b00 the operand is shifted left and the vacated low bits are filled with zeros.
- R2: With mode code 2'b01 the operand is shifted right and the vacated high bits are filled with zeros.
- R3: With mode code 2'b10 or 2'b11 the operand is shifted right and every vacated high bit copies operand bit 31.
- R4: When amtSel is 1 the count is immAmt, zero-extended. When amtSel is 0 the count is regAmtLow. The input that is not selected has no effect on the result.
- R5: In a right shift by n (n from 1 to 31), flagCarry equals bit n-1 of the original operand.
- R6: In a left shift by n (n from 1 to 31), flagCarry equals bit 32-n of the original operand.
- R7: A count of zero returns the operand unchanged and clears flagCarry.
- R8: flagZero is 1 exactly when the registered result is zero. flagSign equals bit 31 of the registered result.
- R9: flagOvf is 0 after every shift.
- R10: outValid is high in the cycle after an inValid cycle and low otherwise. Result and flags update on that same edge.
- R11: While inValid is low, the result and the flags hold their last values.
- R12: After reset, outValid, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands are sampled on this edge |
| mode | input | 2 | 00 left, 01 logical right, 1x arithmetic right |
| amtSel | input | 1 | 1 selects immAmt, 0 selects regAmtLow |
| immAmt | input | 5 | Immediate shift count |
| regAmtLow | input | 5 | Low five bits of the count register |
| operand | input | 32 | Value to shift |
| outValid | output | 1 | Result and flags valid; flag write strobe |
| result | output | 32 | Shifted value |
| flagZero | output | 1 | Result is zero |
| flagSign | output | 1 | Result bit 31 |
| flagCarry | output | 1 | Last bit shifted out |
| flagOvf | output | 1 | Overflow, always cleared |

## Verification
The properties assume that reset is held for at least one edge before the first request. They also assume that the mode, count and operand inputs are stable and known whenever inValid is high. The bench drives every input on the falling edge and never leaves them undriven. The count sources are the only inputs that may change freely, and the bench fills the unselected source with random values so that any leak through it would change the result.

// File: rtl/shift_pkg.sv
`timescale 1ns/1ps
package shift_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    MODE_LSL  = 2'b00,
    MODE_LSR  = 2'b01,
    MODE_ASR  = 2'b10,
    MODE_ASR2 = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic capture;
    logic left;
    logic arith;
    logic useImm;
  } shiftStrobe_t;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } shiftFlags_t;
endpackage

// File: rtl/shift_ctrl.sv
`timescale 1ns/1ps
module shift_ctrl
  import shift_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   mode,
  input  logic         amtSel,
  output shiftStrobe_t strobe,
  output logic         outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.left    = (mode == MODE_LSL);
    strobe.arith   = mode[1];
    strobe.useImm  = amtSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/shift_datapath.sv
`timescale 1ns/1ps
module shift_datapath
  import shift_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobe_t     strobe,
  input  logic [AW-1:0]    immAmt,
  input  logic [AW-1:0]    regAmtLow,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] resultQ,
  output shiftFlags_t      flagsQ
);
  logic [AW-1:0]    amt;
  logic             fillBit;
  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] srcVec;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] revOut;
  logic [WIDTH-1:0] resultD;
  logic [WIDTH:0]   stg [AW+1];

  assign amt     = strobe.useImm ? immAmt : regAmtLow;
  assign fillBit = strobe.arith & operand[WIDTH-1];

  // Left shifts reuse the right shifter on a bit-reversed operand.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign revIn[i]  = operand[WIDTH-1-i];
    assign revOut[i] = shifted[WIDTH-1-i];
  end

  assign srcVec = strobe.left ? revIn : operand;
  // The extra low bit catches whatever falls off last; it becomes carry.
  assign stg[0] = {srcVec, 1'b0};

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {{STEP{fillBit}}, stg[k][WIDTH:STEP]} : stg[k];
  end

  assign shifted = stg[AW][WIDTH:1];
  assign resultD = strobe.left ? revOut : shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else if (strobe.capture) begin
      resultQ      <= resultD;
      flagsQ.zero  <= (resultD == '0);
      flagsQ.sign  <= resultD[WIDTH-1];
      flagsQ.carry <= stg[AW][0];
      flagsQ.ovf   <= 1'b0;
    end
  end
endmodule

// File: rtl/barrel_shift_unit.sv
`timescale 1ns/1ps
module barrel_shift_unit
  import shift_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  mode,
  input  logic        amtSel,
  input  logic [4:0]  immAmt,
  input  logic [4:0]  regAmtLow,
  input  logic [31:0] operand,
  output logic        outValid,
  output logic [31:0] result,
  output logic        flagZero,
  output logic        flagSign,
  output logic        flagCarry,
  output logic        flagOvf
);
  shiftStrobe_t strobe;
  shiftFlags_t  flags;

  shift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .amtSel(amtSel), .strobe(strobe), .outValid(outValid)
  );

  shift_datapath #(.WIDTH(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .immAmt(immAmt),
    .regAmtLow(regAmtLow), .operand(operand), .resultQ(result),
    .flagsQ(flags)
  );

  assign flagZero  = flags.zero;
  assign flagSign  = flags.sign;
  assign flagCarry = flags.carry;
  assign flagOvf   = flags.ovf;
endmodule

// File: rtl/shift_checker.sv
`timescale 1ns/1ps
module shift_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  mode,
  input logic        amtSel,
  input logic [4:0]  immAmt,
  input logic [4:0]  regAmtLow,
  input logic [31:0] operand,
  input logic        outValid,
  input logic [31:0] result,
  input logic        flagZero,
  input logic        flagSign,
  input logic        flagCarry,
  input logic        flagOvf
);
  logic [4:0] effAmt;
  assign effAmt = amtSel ? immAmt : regAmtLow;

  assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !flagOvf);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(flagCarry) && $stable(flagZero)));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagZero == (result == 32'd0)));
  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagSign == result[31]));
  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && effAmt == 5'd0) |=> (result == $past(operand) && !flagCarry));
  assert_asr_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode[1]) |=> (result[31] == $past(operand[31])));
endmodule

bind barrel_shift_unit shift_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .amtSel(amtSel),
  .immAmt(immAmt), .regAmtLow(regAmtLow), .operand(operand),
  .outValid(outValid), .result(result), .flagZero(flagZero),
  .flagSign(flagSign), .flagCarry(flagCarry), .flagOvf(flagOvf)
);

// File: tb/barrel_shift_unit_tb.sv
`timescale 1ns/1ps
module barrel_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        amtSel = 1'b0;
  logic [4:0]  immAmt = '0;
  logic [4:0]  regAmtLow = '0;
  logic [31:0] operand = '0;
  logic        outValid;
  logic [31:0] result;
  logic        flagZero, flagSign, flagCarry, flagOvf;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  barrel_shift_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .amtSel(amtSel),
    .immAmt(immAmt), .regAmtLow(regAmtLow), .operand(operand),
    .outValid(outValid), .result(result), .flagZero(flagZero),
    .flagSign(flagSign), .flagCarry(flagCarry), .flagOvf(flagOvf)
  );

  function automatic logic [31:0] refShift(input logic [1:0] m, input int n,
                                           input logic [31:0] v);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) begin
      if (m == 2'b00)      r = {r[30:0], 1'b0};
      else if (m == 2'b01) r = {1'b0, r[31:1]};
      else                 r = {r[31], r[31:1]};
    end
    return r;
  endfunction

  function automatic logic refCarry(input logic [1:0] m, input int n,
                                    input logic [31:0] v);
    if (n == 0) return 1'b0;
    if (m == 2'b00) return v[32-n];
    return v[n-1];
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runShift(input logic [1:0] m, input logic sel,
                          input logic [4:0] imm, input logic [4:0] ra,
                          input logic [31:0] v, input string resTag);
    int n;
    logic [31:0] expR;
    logic expC;
    string rt, ct;
    n = sel ? int'(imm) : int'(ra);
    expR = refShift(m, n, v);
    expC = refCarry(m, n, v);
    mode = m; amtSel = sel; immAmt = imm; regAmtLow = ra; operand = v;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (resTag.len() != 0) rt = resTag;
    else if (n == 0)       rt = "R7";
    else if (m == 2'b00)   rt = "R1";
    else if (m == 2'b01)   rt = "R2";
    else                   rt = "R3";
    if (n == 0)          ct = "R7 carry";
    else if (m == 2'b00) ct = "R6 carry";
    else                 ct = "R5 carry";
    check(rt, result, expR);
    check(ct, {31'd0, flagCarry}, {31'd0, expC});
    check("R8 zero/sign", {30'd0, flagZero, flagSign},
          {30'd0, expR == 32'd0, expR[31]});
    check("R9 ovf", {31'd0, flagOvf}, 32'd0);
    check("R10 valid", {31'd0, outValid}, 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("R12 reset", {result[31:1], result[0] | outValid | flagZero | flagSign | flagCarry | flagOvf}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep every count in every mode, alternating the count source
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 32; n++) begin
        logic [4:0] junk;
        junk = 5'($urandom);
        if (n % 2 == 0) runShift(2'(m), 1'b1, 5'(n), junk, $urandom, "");
        else            runShift(2'(m), 1'b0, junk, 5'(n), $urandom, "");
      end
    end

    // Directed corners
    runShift(2'b10, 1'b1, 5'd31, 5'd0, 32'h8000_0000, "R3");
    runShift(2'b11, 1'b0, 5'd0, 5'd4, 32'hF000_0000, "R3");
    runShift(2'b01, 1'b1, 5'd31, 5'd0, 32'h8000_0000, "R2");
    runShift(2'b00, 1'b0, 5'd0, 5'd1, 32'h8000_0000, "R1");
    runShift(2'b00, 1'b1, 5'd0, 5'd17, 32'hDEAD_BEEF, "R7");
    // R4: the unselected source must not matter
    runShift(2'b01, 1'b1, 5'd3, 5'd29, 32'h1234_5678, "R4 imm");
    runShift(2'b01, 1'b0, 5'd29, 5'd3, 32'h1234_5678, "R4 reg");

    // R11: hold while idle
    held = result;
    operand = 32'hFFFF_FFFF; immAmt = 5'd9; amtSel = 1'b1; mode = 2'b00;
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R11 hold", result, held);
    check("R10 idle", {31'd0, outValid}, 32'd0);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      runShift(2'($urandom_range(0, 3)), 1'($urandom), 5'($urandom), 5'($urandom),
               $urandom, "");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule